// File: doc/BRIEF.md
# 8-bit ALU with flag register

This block is the arithmetic and logic unit of a small accumulator machine. Each enabled cycle it takes two 8-bit operands and an operation code. It registers the 8-bit result and an 8-bit status byte, and both appear on the outputs one clock later. The flag register is held inside the block. Add-with-carry and subtract-with-borrow read their carry from that register. The decimal-adjust operation reads the stored half-carry, subtract and carry bits, so it must directly follow the BCD add or subtract whose result it corrects.

A single adder serves add, subtract, their carry/borrow forms and negate. A separate unit handles AND, OR and XOR. A third unit applies the BCD correction of 0x06 and/or 0x60. One status bit is shared: it reports two's-complement overflow after arithmetic, and even parity after logical operations and decimal adjust.

Top module: `alu8_core`

## Requirements
- R1: When `op_en` is high at a rising clock edge with a defined code, `res_q` and `flags_q` take the new values after that edge. When `op_en` is low, both hold.
- R2: An active-low asynchronous reset sets `res_q` to 0x00 and `flags_q` to 0x40 (zero flag only).
- R3: Flag byte layout: bit 7 sign (copy of result bit 7), bit 6 zero (result is 0x00), bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Bits 5 and 3 always read 0.
- R4: Code 0 (add) and code 1 (add plus stored carry). Carry out of bit 7 goes to bit 0 and carry out of bit 3 goes to bit 4. Signed overflow goes to bit 2, and the subtract bit is cleared.
- R5: Code 2 (opa minus opb) and code 3 (also minus stored carry). A borrow out of bit 7 sets carry and a borrow out of bit 3 sets half-carry. Signed overflow goes to bit 2, and the subtract bit is set.
- R6: Code 7 yields 0x00 minus opa with the flags of R5. Carry is therefore set for any nonzero opa, and overflow only for opa = 0x80.
- R7: Codes 4 (AND), 5 (XOR) and 6 (OR) clear carry and subtract. Half-carry is 1 for AND and 0 otherwise. Bit 2 is 1 when the result has an even count of ones.
- R8: Code 8 with stored subtract clear adds 0x06 to opa when its low nibble exceeds 9 or stored half-carry is set. It adds 0x60 when opa exceeds 0x99 or stored carry is set. Carry out is the stored carry OR (opa > 0x99). Half-carry out is (low nibble > 9). Bit 2 is the parity of the result.
- R9: Code 8 with stored subtract set subtracts those same corrections. Half-carry out is the stored half-carry AND (low nibble < 6). The subtract bit is left unchanged.
- R10: Codes 9 to 15 change neither `res_q` nor `flags_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_en | input | 1 | Perform the operation this cycle |
| op_sel | input | 4 | Operation code |
| opa | input | 8 | Accumulator operand; the operand of negate and decimal adjust |
| opb | input | 8 | Second operand |
| res_q | output | 8 | Registered result |
| flags_q | output | 8 | Registered status flags |

## Verification
The add path is tried with a low-nibble carry, a positive-to-negative overflow and a wrap to zero, which separate half-carry, overflow and carry from each other. The subtract, borrow and negate patterns include 0x80 and 0x00 operands, so the borrow polarity and the overflow corner are exposed. Logical patterns with odd and even bit counts tell parity apart from overflow. Decimal adjust is driven after real BCD additions and subtractions, covering each correction: low only, high only, both, and a wrap to zero. These chained runs also show that the stored carry, half-carry and subtract bits are consumed.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W = 4;
   localparam int FL_W = 8;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_AND = 4'd4,
      OP_XOR = 4'd5,
      OP_OR  = 4'd6,
      OP_NEG = 4'd7,
      OP_DAA = 4'd8
   } alu_op_e;

   localparam int FL_C  = 0;
   localparam int FL_N  = 1;
   localparam int FL_PV = 2;
   localparam int FL_X3 = 3;
   localparam int FL_H  = 4;
   localparam int FL_X5 = 5;
   localparam int FL_Z  = 6;
   localparam int FL_S  = 7;

   localparam logic [FL_W-1:0] FLAGS_RST = 8'h40;

   function automatic logic even_par(input logic [7:0] v);
      return ~^v;
   endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W = 8,
   parameter int HALF_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              h_out,
   output logic              v_out
);
   localparam int LW = HALF_W + 1;
   localparam int FW = DATA_W + 1;

   logic [DATA_W-1:0] bx;
   logic              cx;
   logic [LW-1:0]     lo;
   logic [FW-1:0]     full;

   generate
      if (HALF_W < 1 || HALF_W >= DATA_W) begin : g_bad_half
         $error("alu8_addsub: HALF_W must lie inside the data word");
      end
   endgenerate

   always_comb begin
      bx    = sub ? ~b : b;
      cx    = cin ^ sub;
      lo    = {1'b0, a[HALF_W-1:0]} + {1'b0, bx[HALF_W-1:0]} + LW'(cx);
      full  = {1'b0, a} + {1'b0, bx} + FW'(cx);
      sum   = full[DATA_W-1:0];
      c_out = full[DATA_W] ^ sub;
      h_out = lo[HALF_W] ^ sub;
      v_out = (a[DATA_W-1] == bx[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int DATA_W        = 8,
   parameter bit AND_SETS_HALF = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        sel,
   output logic [DATA_W-1:0] res,
   output logic              h_out
);
   always_comb begin
      case (sel)
         2'b00:   res = a & b;
         2'b01:   res = a ^ b;
         default: res = a | b;
      endcase
   end

   generate
      if (AND_SETS_HALF) begin : g_and_half
         assign h_out = (sel == 2'b00);
      end else begin : g_no_half
         assign h_out = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
   parameter int DATA_W = 8,
   parameter int HALF_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic              n_in,
   input  logic              h_in,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              h_out,
   output logic              c_out
);
   localparam logic [HALF_W-1:0] DIGIT_MAX = HALF_W'(9);
   localparam logic [HALF_W-1:0] LO_FIX    = HALF_W'(6);
   localparam logic [DATA_W-1:0] BYTE_MAX  = DATA_W'(8'h99);

   logic              lo_big;
   logic              hi_big;
   logic [DATA_W-1:0] corr;

   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_width
         $error("alu8_decadj: data word must be two BCD digits");
      end
   endgenerate

   always_comb begin
      lo_big = a[HALF_W-1:0] > DIGIT_MAX;
      hi_big = a > BYTE_MAX;
      corr   = '0;
      if (h_in || lo_big)
         corr[HALF_W-1:0] = LO_FIX;
      if (c_in || hi_big)
         corr[DATA_W-1:HALF_W] = LO_FIX;
      res   = n_in ? (a - corr) : (a + corr);
      c_out = c_in || hi_big;
      h_out = n_in ? (h_in && (a[HALF_W-1:0] < LO_FIX)) : lo_big;
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int HALF_W        = 4,
   parameter bit AND_SETS_HALF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res_q,
   output logic [FL_W-1:0]   flags_q
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("alu8_core: flag layout and parity assume an 8-bit word");
      end
   endgenerate

   logic [DATA_W-1:0] as_a, as_b, as_res;
   logic              as_sub, as_cin, as_c, as_h, as_v;
   logic [DATA_W-1:0] lg_res;
   logic              lg_h;
   logic [DATA_W-1:0] da_res;
   logic              da_h, da_c;
   logic [DATA_W-1:0] nres;
   logic [FL_W-1:0]   nfl;
   logic              upd;

   always_comb begin
      as_a   = opa;
      as_b   = opb;
      as_sub = 1'b0;
      as_cin = 1'b0;
      case (op_sel)
         OP_ADC: as_cin = flags_q[FL_C];
         OP_SUB: as_sub = 1'b1;
         OP_SBC: begin
            as_sub = 1'b1;
            as_cin = flags_q[FL_C];
         end
         OP_NEG: begin
            as_a   = '0;
            as_b   = opa;
            as_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu8_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_addsub (
      .a(as_a), .b(as_b), .sub(as_sub), .cin(as_cin),
      .sum(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
   );

   alu8_logic #(.DATA_W(DATA_W), .AND_SETS_HALF(AND_SETS_HALF)) u_logic (
      .a(opa), .b(opb), .sel(op_sel[1:0]), .res(lg_res), .h_out(lg_h)
   );

   alu8_decadj #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_decadj (
      .a(opa), .n_in(flags_q[FL_N]), .h_in(flags_q[FL_H]), .c_in(flags_q[FL_C]),
      .res(da_res), .h_out(da_h), .c_out(da_c)
   );

   always_comb begin
      upd  = 1'b1;
      nres = res_q;
      nfl  = flags_q;
      case (op_sel)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            nres        = as_res;
            nfl[FL_C]   = as_c;
            nfl[FL_H]   = as_h;
            nfl[FL_PV]  = as_v;
            nfl[FL_N]   = as_sub;
         end
         OP_AND, OP_XOR, OP_OR: begin
            nres        = lg_res;
            nfl[FL_C]   = 1'b0;
            nfl[FL_H]   = lg_h;
            nfl[FL_PV]  = even_par(lg_res);
            nfl[FL_N]   = 1'b0;
         end
         OP_DAA: begin
            nres        = da_res;
            nfl[FL_C]   = da_c;
            nfl[FL_H]   = da_h;
            nfl[FL_PV]  = even_par(da_res);
         end
         default: upd = 1'b0;
      endcase
      nfl[FL_S]  = nres[DATA_W-1];
      nfl[FL_Z]  = (nres == '0);
      nfl[FL_X5] = 1'b0;
      nfl[FL_X3] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         flags_q <= FLAGS_RST;
      end else if (op_en && upd) begin
         res_q   <= nres;
         flags_q <= nfl;
      end
   end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       op_en,
   input logic [3:0] op_sel,
   input logic [7:0] opa,
   input logic [7:0] opb,
   input logic [7:0] res_q,
   input logic [7:0] flags_q
);
   logic is_logic, is_sub, is_add;
   assign is_logic = (op_sel == OP_AND) || (op_sel == OP_XOR) || (op_sel == OP_OR);
   assign is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBC) || (op_sel == OP_NEG);
   assign is_add   = (op_sel == OP_ADD) || (op_sel == OP_ADC);

   assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[FL_S] == res_q[7]);
   assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[FL_Z] == (res_q == 8'h00));
   assert_spare_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_q[FL_X5] && !flags_q[FL_X3]);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> $stable(res_q) && $stable(flags_q));
   assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_sel == OP_ADD) |=>
         flags_q[FL_C] == (({1'b0, $past(opa)} + {1'b0, $past(opb)}) > 9'h0FF));
   assert_addn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && is_add) |=> !flags_q[FL_N]);
   assert_subn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && is_sub) |=> flags_q[FL_N]);
   assert_logic_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && is_logic) |=> !flags_q[FL_C] && !flags_q[FL_N]);
   assert_keep_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_sel == OP_DAA) |=> flags_q[FL_N] == $past(flags_q[FL_N]));
   assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_sel > OP_DAA) |=> $stable(res_q) && $stable(flags_q));
endmodule

bind alu8_core alu8_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
   .opa(opa), .opb(opb), .res_q(res_q), .flags_q(flags_q)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_en = 1'b0;
   logic [3:0] op_sel = 4'd0;
   logic [7:0] opa = 8'h00;
   logic [7:0] opb = 8'h00;
   logic [7:0] res_q;
   logic [7:0] flags_q;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   alu8_core u_alu8_core (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
      .opa(opa), .opb(opb), .res_q(res_q), .flags_q(flags_q)
   );

   always #2.5 clk = ~clk;

   // {op, a, b, expected result, expected flags}; rows chain through the flag register
   localparam int NV = 28;
   localparam logic [35:0] VEC [0:NV-1] = '{
      {4'h0, 8'h0F, 8'h01, 8'h10, 8'h10},
      {4'h0, 8'h7F, 8'h01, 8'h80, 8'h94},
      {4'h0, 8'hFF, 8'h01, 8'h00, 8'h51},
      {4'h1, 8'h10, 8'h20, 8'h31, 8'h00},
      {4'h1, 8'h10, 8'h20, 8'h30, 8'h00},
      {4'h2, 8'h10, 8'h01, 8'h0F, 8'h12},
      {4'h2, 8'h01, 8'h02, 8'hFF, 8'h93},
      {4'h3, 8'h05, 8'h02, 8'h02, 8'h02},
      {4'h2, 8'h80, 8'h01, 8'h7F, 8'h16},
      {4'h3, 8'h00, 8'h00, 8'h00, 8'h42},
      {4'h4, 8'hF0, 8'h3C, 8'h30, 8'h14},
      {4'h6, 8'h01, 8'h02, 8'h03, 8'h04},
      {4'h5, 8'hFF, 8'h80, 8'h7F, 8'h00},
      {4'h5, 8'h55, 8'h55, 8'h00, 8'h44},
      {4'h7, 8'h01, 8'h00, 8'hFF, 8'h93},
      {4'h7, 8'h80, 8'h00, 8'h80, 8'h87},
      {4'h7, 8'h00, 8'h00, 8'h00, 8'h42},
      {4'h0, 8'h15, 8'h27, 8'h3C, 8'h00},
      {4'h8, 8'h3C, 8'h00, 8'h42, 8'h14},
      {4'h0, 8'h99, 8'h01, 8'h9A, 8'h80},
      {4'h8, 8'h9A, 8'h00, 8'h00, 8'h55},
      {4'h2, 8'h42, 8'h05, 8'h3D, 8'h12},
      {4'h8, 8'h3D, 8'h00, 8'h37, 8'h02},
      {4'h2, 8'h20, 8'h30, 8'hF0, 8'h83},
      {4'h8, 8'hF0, 8'h00, 8'h90, 8'h87},
      {4'h0, 8'h09, 8'h08, 8'h11, 8'h10},
      {4'h8, 8'h11, 8'h00, 8'h17, 8'h04},
      {4'hF, 8'hAA, 8'h55, 8'h17, 8'h04}
   };

   function automatic string req_of(input logic [3:0] op, input logic n_before);
      case (op)
         4'h0, 4'h1:       return "R4";
         4'h2, 4'h3:       return "R5";
         4'h4, 4'h5, 4'h6: return "R7";
         4'h7:             return "R6";
         4'h8:             return n_before ? "R9" : "R8";
         default:          return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] er, input logic [7:0] ef);
      total++;
      if (res_q !== er || flags_q !== ef) begin
         bad++;
         $display("FAIL %s: res=%02h flags=%02h expected res=%02h flags=%02h",
                  tag, res_q, flags_q, er, ef);
      end
   endtask

   task automatic do_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      op_sel = op; opa = a; opb = b; op_en = 1'b1;
      @(negedge clk);
      op_en = 1'b0;
   endtask

   logic [35:0] v;
   logic        n_prev;

   initial begin
      repeat (3) @(negedge clk);
      check("R2 reset", 8'h00, 8'h40);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         n_prev = flags_q[1];
         do_op(v[35:32], v[31:24], v[23:16]);
         check(req_of(v[35:32], n_prev), v[15:8], v[7:0]);
      end

      // R1: enable low, inputs change, nothing moves
      @(negedge clk);
      op_sel = 4'h0; opa = 8'h01; opb = 8'h01; op_en = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 hold", 8'h17, 8'h04);

      // R1: one-cycle latency, result visible after the capturing edge
      do_op(4'h4, 8'hFF, 8'h0F);
      check("R1 capture", 8'h0F, 8'h14);

      // R2: reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R2 mid reset", 8'h00, 8'h40);
      rst_n = 1'b1;

      // R4: add after reset uses no stale carry
      do_op(4'h1, 8'h01, 8'h01);
      check("R4 adc after reset", 8'h02, 8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule